// File: doc/BRIEF.md
# Sector Page-Load Write Controller

This block collects byte writes arriving on a chip-enable / write-enable / output-enable strobe interface into a one-sector staging buffer. Each byte is placed at its offset inside a 128-byte sector, and the bytes may arrive in any order. The length of a write burst is not a byte count. A retriggerable quiet timer measures it instead: once no new byte has arrived for a programmable number of clocks, the buffered sector is committed to a simple on-chip byte array.

A commit runs as one timed operation, and the busy flag is high for all of it. The whole sector is first erased, with every byte written as 0xFF in ascending offset order. The latched bytes are then written back in the same order. Any offset that was never loaded keeps the erased value. The commit lasts a fixed number of clocks, and strobes that arrive during it are discarded.

The strobes are synchronous to the clock. A byte counts only if its write strobe is held long enough, and output-enable must not be asserted across it.

Top module: `sector_load_ctrl`

## Requirements
- R1: After reset, `busy` is 0, `arr_we` is 0 and `sector_out` is 0.
- R2: Address bits [15:7] select the sector and bits [6:0] select the byte offset. Bytes land at their own offsets in whatever order they are loaded, and a second load to the same offset replaces the first.
- R3: A clock cycle is an active strobe cycle when `ce_n`=0, `we_n`=1'b0 and `oe_n`=1. The address is taken in the first cycle of a run of active cycles. The data is taken in the last cycle of that run.
- R4: A run of active cycles shorter than `MIN_PULSE` cycles loads no byte.
- R5: A run that ends because `oe_n` falls while `ce_n` and `we_n` are still low loads no byte. Holding `we_n` low while `ce_n` is high loads no byte.
- R6: A commit begins once `LOAD_WINDOW` strobe-free cycles have passed since the last accepted byte. A byte accepted inside that window restarts the count.
- R7: The first byte of a burst fixes the sector for that burst. Later bytes addressed to another sector are dropped, and every array write goes to the fixed sector.
- R8: A commit first makes 128 array writes of 0xFF to offsets 0 through 127 in ascending order. It then makes 128 writes in ascending offset order carrying the loaded data, with 0xFF at every offset that was not loaded.
- R9: `busy` stays high for exactly `WRITE_CYCLE` cycles per commit. `sector_out` shows the committed sector for the whole of that time.
- R10: Strobes that start while `busy` is high are ignored and do not trigger a later commit. Each new burst starts with an empty buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low; low inhibits writes |
| addr | input | 16 | Byte address: sector [15:7], offset [6:0] |
| din | input | 8 | Write data |
| busy | output | 1 | High while a commit runs |
| sector_out | output | 9 | Sector of the current or most recent commit |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | 16 | Array write address |
| arr_wdata | output | 8 | Array write data |

## Verification
The hardest case to reach is a strobe that begins while a commit is still running. It has to be rejected at its start, and the rejection must stick, so that it neither lands in the buffer nor starts another commit once `busy` falls. The stimulus issues a complete, well-formed write partway through a commit. After the commit it waits longer than a full load window and checks two things: `busy` stays low, and the byte that was written is not in the sector the array received. The other rejection paths are run inside a single burst: short pulses, output-enable aborts, chip-enable-high writes and bytes to a foreign sector. That way the committed image shows each of them separately.

// File: rtl/slc_pkg.sv
// Package: shared types for the sector page-load write controller.
// Assumes nothing beyond standard SystemVerilog.
package slc_pkg;
    // Controller phases: waiting, collecting bytes, erase sweep,
    // program sweep, and the remainder of the fixed commit time.
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_LOAD   = 3'd1,
        PH_ERASE  = 3'd2,
        PH_PROG   = 3'd3,
        PH_SETTLE = 3'd4
    } phase_t;
endpackage

// File: rtl/slc_strobe_filter.sv
// Strobe filter: turns synchronous ce_n/we_n/oe_n levels into one
// qualified "byte loaded" pulse per valid write strobe.
// It takes the address in the first active cycle and the data in the last
// active cycle. It drops runs shorter than MIN_PULSE, runs aborted by oe_n
// and runs that started while the controller was busy.
// Assumes: inputs are already synchronous to clk.
module slc_strobe_filter #(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int MIN_PULSE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic              busy,
    output logic              byte_ok,
    output logic [ADDR_W-1:0] byte_addr,
    output logic [DATA_W-1:0] byte_data,
    output logic              strobe_live
);
    localparam int RUN_W = $clog2(MIN_PULSE + 1) + 1;

    logic              act;
    logic              act_q;
    logic [RUN_W-1:0]  run_cnt;
    logic              blocked;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              end_ok;

    assign act         = !ce_n && !we_n && oe_n;
    assign strobe_live = act || act_q;
    // A run ends validly when ce_n or we_n rises with oe_n still high.
    assign end_ok      = act_q && !act && oe_n && !blocked &&
                         (run_cnt >= RUN_W'(MIN_PULSE));

    // Track the active run: start address, latest data, length, blocking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q   <= 1'b0;
            run_cnt <= '0;
            blocked <= 1'b0;
            addr_q  <= '0;
            data_q  <= '0;
        end else begin
            act_q <= act;
            if (act && !act_q) begin
                addr_q  <= addr;
                data_q  <= din;
                run_cnt <= RUN_W'(1);
                blocked <= busy;
            end else if (act) begin
                data_q <= din;
                if (run_cnt < RUN_W'(MIN_PULSE))
                    run_cnt <= run_cnt + RUN_W'(1);
            end
        end
    end

    // Present a qualified byte for one cycle after the strobe ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_ok   <= 1'b0;
            byte_addr <= '0;
            byte_data <= '0;
        end else begin
            byte_ok <= end_ok;
            if (end_ok) begin
                byte_addr <= addr_q;
                byte_data <= data_q;
            end
        end
    end

    // Independent run-length counter used only by the width assertion.
    logic [RUN_W-1:0] chk_run;
    always_ff @(posedge clk) begin
        if (!rst_n)
            chk_run <= '0;
        else if (!(!ce_n && !we_n && oe_n))
            chk_run <= '0;
        else if (chk_run < RUN_W'(MIN_PULSE))
            chk_run <= chk_run + RUN_W'(1);
    end

    AST_BYTE_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ok |-> $past(chk_run) >= RUN_W'(MIN_PULSE)); // R4
    AST_BYTE_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ok |-> $past(oe_n) && $past(ce_n || we_n)); // R5
endmodule

// File: rtl/slc_page_buffer.sv
// Page buffer: one sector of staged bytes plus a per-offset loaded flag.
// A write sets the byte and its flag, and a clear drops every flag.
// Reads are combinational.
// Assumes SECTOR_BYTES is a power of two.
module slc_page_buffer #(
    parameter int SECTOR_BYTES = 128,
    parameter int DATA_W       = 8,
    localparam int OFS_W       = $clog2(SECTOR_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [OFS_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clear,
    input  logic [OFS_W-1:0]  rd_off,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    logic [DATA_W-1:0]       mem [SECTOR_BYTES];
    logic [SECTOR_BYTES-1:0] loaded;

    // Store byte contents; unloaded entries are never read as data.
    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_off] <= wr_data;
    end

    // Per-offset loaded flags, cleared at reset and at the end of a commit.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            loaded <= '0;
        else if (wr_en)
            loaded[wr_off] <= 1'b1;
    end

    assign rd_data  = mem[rd_off];
    assign rd_valid = loaded[rd_off];
endmodule

// File: rtl/slc_cycle_ctrl.sv
// Cycle controller: locks the sector on the first byte, times the
// retriggerable load window, then runs the fixed-length commit.
// The commit does an erase sweep (all 0xFF), then a program sweep of the
// buffered data (0xFF where nothing was loaded), then waits out the rest.
// Assumes WRITE_CYCLE > 2*SECTOR_BYTES and LOAD_WINDOW >= 1.
module slc_cycle_ctrl
    import slc_pkg::*;
#(
    parameter int ADDR_W       = 16,
    parameter int DATA_W       = 8,
    parameter int SECTOR_BYTES = 128,
    parameter int LOAD_WINDOW  = 150,
    parameter int WRITE_CYCLE  = 1000,
    localparam int OFS_W       = $clog2(SECTOR_BYTES),
    localparam int SEC_W       = ADDR_W - OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_ok,
    input  logic [ADDR_W-1:0] byte_addr,
    input  logic              strobe_live,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              rd_valid,
    output logic              buf_wr,
    output logic              buf_clear,
    output logic [OFS_W-1:0]  rd_off,
    output logic              busy,
    output logic [SEC_W-1:0]  sector_out,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_wdata
);
    localparam int IDLE_W = $clog2(LOAD_WINDOW + 1);
    localparam int CYC_W  = $clog2(WRITE_CYCLE + 1);

    phase_t            phase;
    logic [IDLE_W-1:0] idle_cnt;
    logic [CYC_W-1:0]  cyc_cnt;
    logic [SEC_W-1:0]  lock_sec;
    logic [SEC_W-1:0]  byte_sec;
    logic              sec_match;
    logic              last_cycle;

    assign byte_sec   = byte_addr[ADDR_W-1:OFS_W];
    assign sec_match  = (byte_sec == lock_sec);
    assign busy       = (phase == PH_ERASE) || (phase == PH_PROG) ||
                        (phase == PH_SETTLE);
    assign last_cycle = (cyc_cnt == CYC_W'(WRITE_CYCLE - 1));
    assign buf_wr     = byte_ok && ((phase == PH_IDLE) ||
                                    (phase == PH_LOAD && sec_match));
    assign buf_clear  = (phase == PH_SETTLE) && last_cycle;
    assign rd_off     = cyc_cnt[OFS_W-1:0];

    // Phase sequencing, load-window timer and commit timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_IDLE;
            idle_cnt   <= '0;
            cyc_cnt    <= '0;
            lock_sec   <= '0;
            sector_out <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (byte_ok) begin
                        lock_sec <= byte_sec;
                        idle_cnt <= '0;
                        phase    <= PH_LOAD;
                    end
                end
                PH_LOAD: begin
                    if (byte_ok && sec_match) begin
                        idle_cnt <= '0;
                    end else if (strobe_live) begin
                        idle_cnt <= idle_cnt;
                    end else if (idle_cnt == IDLE_W'(LOAD_WINDOW - 1)) begin
                        cyc_cnt    <= '0;
                        sector_out <= lock_sec;
                        phase      <= PH_ERASE;
                    end else begin
                        idle_cnt <= idle_cnt + IDLE_W'(1);
                    end
                end
                PH_ERASE: begin
                    cyc_cnt <= cyc_cnt + CYC_W'(1);
                    if (cyc_cnt == CYC_W'(SECTOR_BYTES - 1))
                        phase <= PH_PROG;
                end
                PH_PROG: begin
                    cyc_cnt <= cyc_cnt + CYC_W'(1);
                    if (cyc_cnt == CYC_W'(2 * SECTOR_BYTES - 1))
                        phase <= PH_SETTLE;
                end
                PH_SETTLE: begin
                    cyc_cnt <= cyc_cnt + CYC_W'(1);
                    if (last_cycle)
                        phase <= PH_IDLE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Registered array write port driven by the erase and program sweeps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arr_we    <= 1'b0;
            arr_addr  <= '0;
            arr_wdata <= '0;
        end else begin
            arr_we    <= (phase == PH_ERASE) || (phase == PH_PROG);
            arr_addr  <= {sector_out, cyc_cnt[OFS_W-1:0]};
            if (phase == PH_PROG && rd_valid)
                arr_wdata <= rd_data;
            else
                arr_wdata <= '1;
        end
    end

    // Checker: busy-run length counted apart from the commit timer.
    logic [CYC_W-1:0] chk_busy_len;
    always_ff @(posedge clk) begin
        if (!rst_n)
            chk_busy_len <= '0;
        else if (busy)
            chk_busy_len <= chk_busy_len + CYC_W'(1);
        else
            chk_busy_len <= '0;
    end

    AST_BUSY_NOT_LONG: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> chk_busy_len < CYC_W'(WRITE_CYCLE)); // R9
    AST_BUSY_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> chk_busy_len == CYC_W'(WRITE_CYCLE)); // R9
    AST_NO_LOAD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !buf_wr); // R10
    AST_ARR_IN_SECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy && arr_addr[ADDR_W-1:OFS_W] == sector_out); // R7
    AST_ERASE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we && $past(phase == PH_ERASE) |-> arr_wdata == '1); // R8
endmodule

// File: rtl/sector_load_ctrl.sv
// Top: sector page-load write controller. It connects the strobe filter,
// the page buffer and the cycle controller.
// Assumes synchronous strobes, a power-of-two sector size and
// WRITE_CYCLE > 2*SECTOR_BYTES.
module sector_load_ctrl #(
    parameter int ADDR_W       = 16,
    parameter int DATA_W       = 8,
    parameter int SECTOR_BYTES = 128,
    parameter int MIN_PULSE    = 2,
    parameter int LOAD_WINDOW  = 150,
    parameter int WRITE_CYCLE  = 1000,
    localparam int OFS_W       = $clog2(SECTOR_BYTES),
    localparam int SEC_W       = ADDR_W - OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              busy,
    output logic [SEC_W-1:0]  sector_out,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_wdata
);
    logic              byte_ok;
    logic [ADDR_W-1:0] byte_addr;
    logic [DATA_W-1:0] byte_data;
    logic              strobe_live;
    logic              buf_wr;
    logic              buf_clear;
    logic [OFS_W-1:0]  rd_off;
    logic [DATA_W-1:0] rd_data;
    logic              rd_valid;

    slc_strobe_filter #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MIN_PULSE(MIN_PULSE)
    ) u_filter (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .busy(busy), .byte_ok(byte_ok),
        .byte_addr(byte_addr), .byte_data(byte_data),
        .strobe_live(strobe_live)
    );

    slc_page_buffer #(
        .SECTOR_BYTES(SECTOR_BYTES), .DATA_W(DATA_W)
    ) u_buffer (
        .clk(clk), .rst_n(rst_n), .wr_en(buf_wr),
        .wr_off(byte_addr[OFS_W-1:0]), .wr_data(byte_data),
        .clear(buf_clear), .rd_off(rd_off), .rd_data(rd_data),
        .rd_valid(rd_valid)
    );

    slc_cycle_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECTOR_BYTES(SECTOR_BYTES),
        .LOAD_WINDOW(LOAD_WINDOW), .WRITE_CYCLE(WRITE_CYCLE)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .byte_ok(byte_ok), .byte_addr(byte_addr),
        .strobe_live(strobe_live), .rd_data(rd_data), .rd_valid(rd_valid),
        .buf_wr(buf_wr), .buf_clear(buf_clear), .rd_off(rd_off),
        .busy(busy), .sector_out(sector_out), .arr_we(arr_we),
        .arr_addr(arr_addr), .arr_wdata(arr_wdata)
    );
endmodule

// File: tb/sector_load_ctrl_bench.sv
// Bench for sector_load_ctrl: a table of byte loads, then directed tests.
module sector_load_ctrl_bench;
    localparam int MINP = 3;
    localparam int LWIN = 40;
    localparam int WCYC = 300;
    localparam int NLOAD = 6;
    // {address, data}; sector 0x0A5 has base address 0x5280.
    localparam logic [23:0] LOADS [NLOAD] = '{
        {16'h52FF, 8'h3C}, {16'h5280, 8'hA1}, {16'h52C0, 8'h0F},
        {16'h5293, 8'hE7}, {16'h52C0, 8'h5B}, {16'h5281, 8'h00}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [15:0] addr = '0;
    logic [7:0]  din = '0;
    logic        busy;
    logic [8:0]  sector_out;
    logic        arr_we;
    logic [15:0] arr_addr;
    logic [7:0]  arr_wdata;

    int tests = 0, fails = 0;
    logic [7:0] exp_img [128];
    logic [7:0] mdl_img [128];
    logic [8:0] cur_sec = '0;
    int  widx = 0, mon_err = 0, bcnt = 0, last_len = 0, done_cnt = 0;
    logic prev_busy = 1'b0;
    bit  finished = 1'b0;

    always #4 clk = ~clk;

    sector_load_ctrl #(.MIN_PULSE(MINP), .LOAD_WINDOW(LWIN), .WRITE_CYCLE(WCYC))
    u_sector_load_ctrl (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .busy(busy), .sector_out(sector_out),
        .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata)
    );

    // Monitor: array model, sweep order, busy length (sampled at negedge).
    always @(negedge clk) begin
        if (busy && !prev_busy) begin
            widx = 0;
            mon_err = 0;
        end
        if (arr_we) begin
            if (arr_addr[15:7] != cur_sec) mon_err++;
            if (widx < 128) begin
                if (arr_wdata != 8'hFF || int'(arr_addr[6:0]) != widx) mon_err++;
            end else if (widx < 256) begin
                if (int'(arr_addr[6:0]) != widx - 128) mon_err++;
                mdl_img[arr_addr[6:0]] = arr_wdata;
            end else mon_err++;
            widx++;
        end
        if (busy) bcnt++;
        else if (bcnt != 0) begin
            last_len = bcnt;
            bcnt = 0;
            done_cnt++;
        end
        prev_busy = busy;
    end

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One strobe: address valid only in the first cycle, data only in the last.
    // mode 0 ends with we_n rising, mode 1 ends with oe_n falling (abort).
    task automatic write_byte(input logic [15:0] a, input logic [7:0] d,
                              input int len, input int mode);
        @(negedge clk);
        ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = a;
        din = (len == 1) ? d : ~d;
        for (int i = 1; i < len; i++) begin
            @(negedge clk);
            addr = a ^ 16'h5555;
            din = (i == len - 1) ? d : ~d;
        end
        @(negedge clk);
        if (mode == 0) we_n = 1'b1; else oe_n = 1'b0;
        addr = ~a; din = 8'h99;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic clear_exp(input logic [8:0] s);
        cur_sec = s;
        for (int i = 0; i < 128; i++) begin
            exp_img[i] = 8'hFF;
            mdl_img[i] = 8'h00;
        end
    endtask

    // Wait for commit; optionally issue a write while busy (R10).
    task automatic run_commit(input string req, input int inject);
        int n = 0;
        int d0 = done_cnt;
        while (!busy && n < 4 * LWIN) begin @(negedge clk); n++; end
        check({req, " commit started"}, int'(busy), 1);
        check("R9 sector_out during commit", int'(sector_out), int'(cur_sec));
        if (inject != 0) begin
            idle(10);
            write_byte({cur_sec, 7'h20}, 8'h77, 4, 0);   // R10 ignored
        end
        n = 0;
        while (done_cnt == d0 && n < 2 * WCYC) begin @(negedge clk); n++; end
        check("R9 busy length", last_len, WCYC);
        check("R8 sweep order and erase value", mon_err, 0);
        check("R8 array write count", widx, 256);
    endtask

    task automatic compare(input string req);
        for (int i = 0; i < 128; i++)
            check(req, int'(mdl_img[i]), int'(exp_img[i]));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        idle(4);
        // R1: reset values.
        check("R1 busy", int'(busy), 0);
        check("R1 arr_we", int'(arr_we), 0);
        check("R1 sector_out", int'(sector_out), 0);
        rst_n = 1'b1;
        idle(3);

        // R2/R3: table of out-of-order loads with an overwrite.
        clear_exp(9'h0A5);
        for (int k = 0; k < NLOAD; k++) begin
            write_byte(LOADS[k][23:8], LOADS[k][7:0], 4, 0);
            exp_img[LOADS[k][14:8]] = LOADS[k][7:0];
            idle(5);
            check("R6 no commit inside window", int'(busy), 0);
        end
        run_commit("R2", 0);
        compare("R2 R3 sector image");

        // R4, R5, R7, R10: rejected loads inside one burst to sector 3.
        clear_exp(9'h003);
        write_byte(16'h0185, 8'h11, 4, 0);               // accepted
        exp_img[7'h05] = 8'h11;
        write_byte(16'h0186, 8'h22, MINP - 1, 0);        // R4 too short
        write_byte(16'h0187, 8'h33, 5, 1);               // R5 oe abort
        write_byte(16'h0208, 8'h44, 4, 0);               // R7 other sector
        @(negedge clk);                                  // R5 ce_n high
        ce_n = 1'b1; we_n = 1'b0; oe_n = 1'b1; addr = 16'h0189; din = 8'h55;
        idle(6);
        we_n = 1'b1;
        run_commit("R7", 1);
        compare("R4 R5 R7 R10 sector image");
        idle(LWIN + 20);
        check("R10 no commit from busy strobe", int'(busy), 0);

        // R6: window restarts on each accepted byte; fresh buffer (R10).
        clear_exp(9'h1C0);
        write_byte(16'hE002, 8'h9C, 4, 0);
        exp_img[2] = 8'h9C;
        idle(LWIN - 8);
        check("R6 still loading after first byte", int'(busy), 0);
        write_byte(16'hE003, 8'hC9, 4, 0);
        exp_img[3] = 8'hC9;
        idle(LWIN - 8);
        check("R6 window restarted", int'(busy), 0);
        run_commit("R6", 0);
        compare("R6 R10 sector image");

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule